// File: doc/BRIEF.md
# CAN Interframe Space Monitor

This block follows the sampled CAN bus level once a frame's end-of-frame field has finished and decides what each bit of the gap before the next frame means. It takes one sampled bit for each bit-time strobe, plus a one-cycle pulse that marks the end of the end-of-frame field. It reports three things: a start-of-frame pulse, an overload request pulse, and a level flag that is high while the bus is idle.

A dominant bit does not always mean the same thing. In the first two intermission slots it is an overload condition. In the last slot, or at any point during bus idle, it starts the next frame. After reset the monitor does not trust the bus until it has seen a run of recessive bits, and only then does it declare the bus idle. Overload frame generation, error counting and bit timing belong to neighbouring blocks.

The bit input is a strobed stream with no ready signal. The bus cannot be stalled, so there is no back-pressure: every strobed bit is used in the cycle it arrives. Between strobes the bit input is ignored. The end-of-frame pulse and all outputs are plain control pins.

Top module: `can_ifs_monitor`

## Requirements
- R1: After reset, `bus_idle` is 0 and no pulse is issued. `bus_idle` rises in the cycle after the strobe of the SYNC_BITS-th (default 11) consecutive recessive bit.
- R2: During that start-up wait, a strobed dominant bit restarts the run of recessive bits from zero and produces no pulse.
- R3: While a frame is in progress, strobed bits are ignored. `eof_done` starts the intermission, and a strobe in the same cycle as `eof_done` is not counted as an intermission slot.
- R4: A strobed dominant bit in intermission slot 1 or 2 raises `overload_req` for that strobe's cycle and returns the monitor to the in-frame state.
- R5: A strobed dominant bit in intermission slot 3 raises `sof_det` for that strobe's cycle.
- R6: After three strobed recessive intermission bits, `bus_idle` rises in the cycle after the third strobe.
- R7: A strobed dominant bit during bus idle raises `sof_det` in that cycle, and `bus_idle` falls in the next cycle.
- R8: After an overload request, strobed bits of either level have no effect until a new `eof_done` arrives.
- R9: The bit encoding is 1 = recessive and 0 = dominant. `sof_det` and `overload_req` last one cycle, occur only in a strobe cycle, never occur together, and `bus_bit` is ignored when there is no strobe.
- R10: `eof_done` has no effect while the bus is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_strobe | input | 1 | Qualifies `bus_bit` for one cycle per bit time |
| bus_bit | input | 1 | Sampled bus level, 1 = recessive, 0 = dominant |
| eof_done | input | 1 | One-cycle pulse at the end of the end-of-frame field |
| sof_det | output | 1 | Start-of-frame detected, in the strobe cycle of the bit that caused it |
| overload_req | output | 1 | Overload condition, in the strobe cycle of the bit that caused it |
| bus_idle | output | 1 | High while the bus is idle |

## Verification
The table-driven run places a dominant bit in each of the three intermission slots and during idle. This separates the overload outcome from the start-of-frame outcome at the slot 2/3 boundary. Runs with gaps between strobes, and with dominant bits that arrive without a strobe, show that only strobed bits advance the slot count. A strobe that arrives together with `eof_done`, an `eof_done` during idle, and bits that follow an overload show which events are ignored. Directed runs break the start-up recessive run one bit short of its length, and apply reset in the middle of operation.

// File: rtl/can_ifs_pkg.sv
package can_ifs_pkg;
  typedef enum logic [1:0] {
    ST_SYNC  = 2'd0,
    ST_FRAME = 2'd1,
    ST_INTER = 2'd2,
    ST_IDLE  = 2'd3
  } ifs_state_e;
endpackage

// File: rtl/can_ifs_bit_counter.sv
module can_ifs_bit_counter #(
  parameter int MAX_COUNT = 11,
  localparam int CW = $clog2(MAX_COUNT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count <= '0;
    else if (clr)    count <= '0;
    else if (inc && count != CW'(MAX_COUNT)) count <= count + 1'b1;
  end

  // counter stays within its range (supports R1, R6)
  assert_count_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(MAX_COUNT));
endmodule

// File: rtl/can_ifs_fsm.sv
module can_ifs_fsm
  import can_ifs_pkg::*;
#(
  parameter int SYNC_BITS   = 11,
  parameter int INTER_SLOTS = 3,
  parameter int CW          = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_strobe,
  input  logic          bus_bit,
  input  logic          eof_done,
  input  logic [CW-1:0] count,
  output logic          cnt_clr,
  output logic          cnt_inc,
  output logic          sof_det,
  output logic          overload_req,
  output logic          bus_idle
);
  localparam logic [CW-1:0] SYNC_LAST  = CW'(SYNC_BITS - 1);
  localparam logic [CW-1:0] INTER_LAST = CW'(INTER_SLOTS - 1);

  ifs_state_e state, state_nx;
  logic dom_bit, rec_bit;

  assign dom_bit = bit_strobe && !bus_bit;
  assign rec_bit = bit_strobe &&  bus_bit;

  always_comb begin
    state_nx     = state;
    cnt_clr      = 1'b0;
    cnt_inc      = 1'b0;
    sof_det      = 1'b0;
    overload_req = 1'b0;
    unique case (state)
      ST_SYNC: begin
        if (rec_bit) begin
          if (count == SYNC_LAST) begin
            state_nx = ST_IDLE;
            cnt_clr  = 1'b1;
          end else begin
            cnt_inc = 1'b1;
          end
        end else if (dom_bit) begin
          cnt_clr = 1'b1;
        end
      end
      ST_FRAME: begin
        if (eof_done) begin
          state_nx = ST_INTER;
          cnt_clr  = 1'b1;
        end
      end
      ST_INTER: begin
        if (dom_bit) begin
          if (count < INTER_LAST) overload_req = 1'b1;
          else                    sof_det      = 1'b1;
          state_nx = ST_FRAME;
          cnt_clr  = 1'b1;
        end else if (rec_bit) begin
          if (count == INTER_LAST) begin
            state_nx = ST_IDLE;
            cnt_clr  = 1'b1;
          end else begin
            cnt_inc = 1'b1;
          end
        end
      end
      ST_IDLE: begin
        if (dom_bit) begin
          sof_det  = 1'b1;
          state_nx = ST_FRAME;
        end
      end
      default: state_nx = ST_SYNC;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_SYNC;
    else        state <= state_nx;
  end

  assign bus_idle = (state == ST_IDLE);

  // pulses only on strobed dominant bits
  assert_pulse_needs_dominant_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sof_det || overload_req) |-> (bit_strobe && !bus_bit));
  assert_pulses_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(sof_det && overload_req));
  // start of frame during idle clears the idle flag
  assert_sof_clears_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sof_det && bus_idle) |=> !bus_idle);
  // idle only follows a strobed recessive bit
  assert_idle_after_recessive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_idle) |-> $past(bit_strobe && bus_bit));
  // overload never reported while idle
  assert_no_overload_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    overload_req |-> !bus_idle);
  // after overload nothing is reported until the next eof_done
  assert_overload_then_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    overload_req |=> (!sof_det && !overload_req && !bus_idle));
endmodule

// File: rtl/can_ifs_monitor.sv
module can_ifs_monitor #(
  parameter int SYNC_BITS   = 11,
  parameter int INTER_SLOTS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_strobe,
  input  logic bus_bit,
  input  logic eof_done,
  output logic sof_det,
  output logic overload_req,
  output logic bus_idle
);
  localparam int MAX_COUNT = (SYNC_BITS > INTER_SLOTS) ? SYNC_BITS : INTER_SLOTS;
  localparam int CW        = $clog2(MAX_COUNT + 1);

  logic          cnt_clr, cnt_inc;
  logic [CW-1:0] count;

  can_ifs_bit_counter #(.MAX_COUNT(MAX_COUNT)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .inc   (cnt_inc),
    .count (count)
  );

  can_ifs_fsm #(
    .SYNC_BITS   (SYNC_BITS),
    .INTER_SLOTS (INTER_SLOTS),
    .CW          (CW)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .bit_strobe   (bit_strobe),
    .bus_bit      (bus_bit),
    .eof_done     (eof_done),
    .count        (count),
    .cnt_clr      (cnt_clr),
    .cnt_inc      (cnt_inc),
    .sof_det      (sof_det),
    .overload_req (overload_req),
    .bus_idle     (bus_idle)
  );
endmodule

// File: tb/can_ifs_monitor_tb.sv
module can_ifs_monitor_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_strobe = 1'b0;
  logic bus_bit = 1'b1;
  logic eof_done = 1'b0;
  logic sof_det, overload_req, bus_idle;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  can_ifs_monitor u_dut (
    .clk(clk), .rst_n(rst_n), .bit_strobe(bit_strobe), .bus_bit(bus_bit),
    .eof_done(eof_done), .sof_det(sof_det), .overload_req(overload_req),
    .bus_idle(bus_idle)
  );

  // {req[3:0], eof, strobe, bit, exp_sof, exp_ovl, exp_idle}
  localparam int NV = 36;
  localparam logic [9:0] VEC [NV] = '{
    {4'd1, 6'b011000}, {4'd1, 6'b011000}, {4'd1, 6'b011000}, {4'd1, 6'b011000}, // R1 start-up run
    {4'd1, 6'b011000}, {4'd1, 6'b011000}, {4'd1, 6'b011000}, {4'd1, 6'b011000},
    {4'd1, 6'b011000}, {4'd1, 6'b011000},
    {4'd9, 6'b000000},  // R9 dominant without strobe ignored
    {4'd1, 6'b011000},  // 11th recessive
    {4'd1, 6'b000001},  // R1 idle now high
    {4'd7, 6'b010101},  // R7 sof while idle
    {4'd3, 6'b010000},  // R3 in-frame strobe ignored, idle dropped
    {4'd3, 6'b101000},  // eof_done
    {4'd4, 6'b010010},  // R4 dominant slot 1 -> overload
    {4'd8, 6'b011000},  // R8 ignored after overload
    {4'd8, 6'b010000},
    {4'd3, 6'b101000},  // eof_done
    {4'd6, 6'b011000},  // slot 1 recessive
    {4'd4, 6'b010010},  // R4 dominant slot 2 -> overload
    {4'd3, 6'b101000},
    {4'd6, 6'b011000}, {4'd6, 6'b011000},
    {4'd5, 6'b010100},  // R5 dominant slot 3 -> sof
    {4'd3, 6'b110000},  // R3 eof with simultaneous strobe, not a slot
    {4'd6, 6'b011000}, {4'd6, 6'b011000},
    {4'd9, 6'b000000},  // gap with no strobe
    {4'd6, 6'b011000},  // third recessive slot
    {4'd6, 6'b001001},  // R6 idle high
    {4'd10, 6'b101001}, // R10 eof_done while idle ignored
    {4'd10, 6'b011001},
    {4'd7, 6'b010101},  // R7 sof from idle
    {4'd7, 6'b001000}   // idle dropped
  };

  task automatic check(input string what, input int req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic step(input logic e, input logic s, input logic b,
                      input logic xs, input logic xo, input logic xi, input int req);
    @(negedge clk);
    eof_done = e; bit_strobe = s; bus_bit = b;
    #2;
    check("sof_det", req, sof_det, xs);
    check("overload_req", req, overload_req, xo);
    check("bus_idle", req, bus_idle, xi);
  endtask

  initial begin
    int wd = 0;
    while (!done && wd < 20000) begin
      @(posedge clk);
      wd++;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    bit_strobe = 1'b1; bus_bit = 1'b0;
    repeat (3) @(negedge clk);
    check("sof_det in reset", 1, sof_det, 1'b0);
    check("overload_req in reset", 1, overload_req, 1'b0);
    check("bus_idle in reset", 1, bus_idle, 1'b0);
    bit_strobe = 1'b0; bus_bit = 1'b1;
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][5], VEC[i][4], VEC[i][3], VEC[i][2], VEC[i][1], VEC[i][0], int'(VEC[i][9:6]));
    end

    // reset in mid-operation, then R2: broken run restarts the count
    @(negedge clk);
    rst_n = 1'b0; eof_done = 1'b0; bit_strobe = 1'b0;
    @(negedge clk);
    check("bus_idle after mid reset", 1, bus_idle, 1'b0);
    rst_n = 1'b1;
    for (int i = 0; i < 10; i++) step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 2);
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2);   // R2 dominant: no pulse, restart
    for (int i = 0; i < 10; i++) step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 2);
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2);   // R2 still not idle after 10
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 2);   // 11th
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1);   // R1 idle
    @(negedge clk);
    bit_strobe = 1'b0; eof_done = 1'b0;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule